// File: doc/BRIEF.md
# Bus-Serviced Watchdog Timer

This block is a watchdog timer that a host services through ordinary traffic on a two-wire serial bus rather than through a dedicated service pin. Both bus lines are brought into the clock domain through a synchronizer chain. A small recognizer then watches the synchronized lines for a fixed pattern: the data line falls, the clock line then falls, and the bus later sees a stop, meaning the data line rises while the clock line is high. Only a completed pattern restarts the timeout counter.

A 2-bit select input picks one of four timeout lengths, counted in clock cycles. If the counter reaches the selected length before a restart, the active-low watchdog output is asserted. It stays asserted until a complete service pattern arrives. That pattern clears the counter and releases the output in the same step. The lengths are parameters. Their default values are kept short so that simulation stays fast.

Top module: `buswd_top`

## Requirements
- R1: After reset, wdo_n is high and the counter starts from zero. With no bus activity, wdo_n goes low on exactly the lim-th rising clock edge after rst_n is released, where lim is the selected timeout.
- R2: The select code tsel maps to a timeout in clock cycles: 0 gives 64, 1 gives 128, 2 gives 256 and 3 gives 512.
- R3: A complete service pattern restarts the timeout. The pattern is an SDA fall, then an SCL fall, then SDA rising while SCL is high. After it, wdo_n stays high for at least 3/4 of the selected timeout.
- R4: If no complete service pattern arrives, wdo_n goes low no later than 10 cycles after the selected timeout has elapsed since the last restart.
- R5: Once wdo_n is low, it stays low for any length of time until a complete service pattern arrives. It returns high within 6 clock cycles of the stop edge on the pins.
- R6: A partial pattern does not restart the timer. A partial pattern is an SDA fall and an SCL fall, followed by SDA rising while SCL is low and then SCL rising, with no stop.
- R7: An SDA fall followed directly by a stop, with no SCL fall between them, does not restart the timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Serial clock line, asynchronous to clk, idles high |
| sda | input | 1 | Serial data line, asynchronous to clk, idles high |
| tsel | input | 2 | Timeout select code |
| wdo_n | output | 1 | Watchdog output, low when the timeout has expired |

## Verification
The hardest situation to reach is a bus pattern that comes very close to a valid service but is not one. One case is a stop that appears before any clock fall. The other is a data rise that happens while the clock is low, so it never forms a stop. Directed sequences build each of these near-misses right after a valid restart. The bench then confirms that the output still falls at the original deadline. Randomly chosen select codes and restart gaps, spread on both sides of the deadline, test the countdown and the release under varied conditions.

// File: rtl/buswd_pkg.sv
package buswd_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE    = 2'd0,
      SQ_ARMED   = 2'd1,
      SQ_CLOCKED = 2'd2
   } seq_state_t;
endpackage

// File: rtl/buswd_sync.sv
module buswd_sync #(
   parameter int unsigned W      = 2,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("buswd_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/buswd_seq.sv
module buswd_seq
   import buswd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic kick
);
   logic       scl_q, sda_q;
   logic       sda_fall, scl_fall, stop_seen;
   seq_state_t st, st_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign sda_fall  = sda_q & ~sda_s;
   assign scl_fall  = scl_q & ~scl_s;
   assign stop_seen = ~sda_q & sda_s & scl_q & scl_s;

   always_comb begin
      st_nx = st;
      unique case (st)
         SQ_IDLE:    if (sda_fall) st_nx = SQ_ARMED;
         SQ_ARMED: begin
            if (scl_fall)       st_nx = SQ_CLOCKED;
            else if (stop_seen) st_nx = SQ_IDLE;
         end
         SQ_CLOCKED: if (stop_seen) st_nx = SQ_IDLE;
         default:    st_nx = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= SQ_IDLE;
         kick <= 1'b0;
      end else begin
         st   <= st_nx;
         kick <= (st == SQ_CLOCKED) && stop_seen;
      end
   end
endmodule

// File: rtl/buswd_timer.sv
module buswd_timer #(
   parameter int unsigned TO0   = 64,
   parameter int unsigned TO1   = 128,
   parameter int unsigned TO2   = 256,
   parameter int unsigned TO3   = 512,
   parameter int unsigned CNT_W = $clog2(TO3 + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       tsel,
   input  logic             kick,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] lim,
   output logic             wdo_n
);
   always_comb begin
      unique case (tsel)
         2'd0:    lim = CNT_W'(TO0);
         2'd1:    lim = CNT_W'(TO1);
         2'd2:    lim = CNT_W'(TO2);
         default: lim = CNT_W'(TO3);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         wdo_n <= 1'b1;
      end else if (kick) begin
         cnt   <= '0;
         wdo_n <= 1'b1;
      end else if (cnt >= lim - 1'b1) begin
         wdo_n <= 1'b0;
      end else begin
         cnt   <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/buswd_top.sv
module buswd_top #(
   parameter int unsigned TO0         = 64,
   parameter int unsigned TO1         = 128,
   parameter int unsigned TO2         = 256,
   parameter int unsigned TO3         = 512,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl,
   input  logic       sda,
   input  logic [1:0] tsel,
   output logic       wdo_n
);
   localparam int unsigned CNT_W = $clog2(TO3 + 1);

   if (TO0 < 2 || TO1 < TO0 || TO2 < TO1 || TO3 < TO2) begin : g_bad_timeouts
      $error("buswd_top: timeouts must be at least 2 and non-decreasing");
   end

   logic [1:0]       bus_s;
   logic             kick;
   logic [CNT_W-1:0] cnt, lim;

   buswd_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl, sda}), .q(bus_s)
   );

   buswd_seq u_seq (
      .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]), .kick(kick)
   );

   buswd_timer #(.TO0(TO0), .TO1(TO1), .TO2(TO2), .TO3(TO3), .CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .tsel(tsel), .kick(kick),
      .cnt(cnt), .lim(lim), .wdo_n(wdo_n)
   );
endmodule

// File: rtl/buswd_chk.sv
module buswd_chk #(
   parameter int unsigned CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wdo_n,
   input logic             kick,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] lim
);
   assert_kick_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> !kick);

   assert_kick_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> (cnt == '0));

   assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> wdo_n);

   assert_hold_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wdo_n && !kick) |=> !wdo_n);

   assert_fall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdo_n) |-> ($past(cnt) >= $past(lim) - 1'b1));
endmodule

bind buswd_top buswd_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wdo_n(wdo_n), .kick(kick), .cnt(cnt), .lim(lim)
);

// File: tb/sim_buswd_top.sv
`timescale 1ns/1ps
module sim_buswd_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda = 1'b1;
   logic [1:0] tsel = 2'd0;
   logic       wdo_n;
   int         checks = 0;
   int         errors = 0;

   always #2.5 clk = ~clk;

   buswd_top u0 (
      .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda), .tsel(tsel), .wdo_n(wdo_n)
   );

   function automatic int exp_lim(input logic [1:0] s);
      case (s)
         2'd0:    return 64;
         2'd1:    return 128;
         2'd2:    return 256;
         default: return 512;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // full service pattern, ends on the stop edge
   task automatic service();
      sda = 1'b0; idle(3);
      scl = 1'b0; idle(3);
      scl = 1'b1; idle(3);
      sda = 1'b1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; scl = 1'b1; sda = 1'b1;
      idle(3);
      rst_n = 1'b1;
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int seed_init;
      seed_init = $urandom(32'd4711);

      // R1 / R2: exact expiry after reset for every select code
      for (int s = 0; s < 4; s++) begin
         int n;
         tsel = 2'(s);
         do_reset();
         chk(wdo_n == 1'b1, "R1 reset state", int'(wdo_n), 1);
         n = 0;
         while (wdo_n && n < 2000) begin
            @(negedge clk);
            n++;
         end
         chk(n == exp_lim(2'(s)), "R1 R2 expiry edge after reset", n, exp_lim(2'(s)));
      end

      // R5: stays low indefinitely, released by a service pattern
      tsel = 2'd0;
      idle(3 * 64);
      chk(wdo_n == 1'b0, "R5 held low", int'(wdo_n), 0);
      service();
      idle(6);
      chk(wdo_n == 1'b1, "R5 release after stop", int'(wdo_n), 1);

      // R7: stop with no clock fall in between
      service();
      idle(20);
      sda = 1'b0; idle(3);
      sda = 1'b1;
      idle(64 + 10 - 23);
      chk(wdo_n == 1'b0, "R7 start-stop ignored", int'(wdo_n), 0);

      // R6: partial pattern, data rises with clock low
      service();
      idle(20);
      sda = 1'b0; idle(3);
      scl = 1'b0; idle(3);
      sda = 1'b1; idle(3);
      scl = 1'b1;
      idle(64 + 10 - 29);
      chk(wdo_n == 1'b0, "R6 partial ignored", int'(wdo_n), 0);

      // R3 / R4 / R5: random select codes and gaps
      for (int t = 0; t < 40; t++) begin
         int l, gap;
         tsel = 2'($urandom % 4);
         l = exp_lim(tsel);
         service();
         idle(6);
         chk(wdo_n == 1'b1, "R5 release", int'(wdo_n), 1);
         if ($urandom % 2) begin
            gap = l / 4 + int'($urandom % (l / 2));
            idle(gap - 6);
            chk(wdo_n == 1'b1, "R3 restart holds high", int'(wdo_n), 1);
         end else begin
            gap = l + 10 + int'($urandom % 20);
            idle(gap - 6);
            chk(wdo_n == 1'b0, "R4 expiry after timeout", int'(wdo_n), 0);
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule